// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Threshold Flags

This block is a 9-bit first-in first-out buffer whose producer and consumer run on unrelated clocks. The depth is a parameter chosen from 256, 512, 1024, 2048, 4096 or 8192 words. Each side qualifies its transfers with a pair of active-low enables, and a transfer happens only when both enables of that pair are low at the side's rising clock edge.

The stream rules work as follows. The two write enables together act as the producer's valid. `full` acts as the inverse of ready: a write offered while `full` is high is dropped, so the producer must hold its word until `full` falls. On the consumer side the two read enables act as the request. `empty` acts as the inverse of valid: a read requested while `empty` is high does nothing. An accepted read presents its word on `rd_data` one read-clock cycle later.

There are two active-low threshold flags. `almost_full_n` is computed in the write domain against an offset loaded in parallel on the write clock. `almost_empty_n` is computed in the read domain against an offset loaded on the read clock. Pointers cross between domains as Gray codes through two-flop synchronizers. As a result, a flag sees the other side's activity a few of its own clock edges late.

Top module: `dcfifo_thresh`

## Requirements
- R1: A word is stored at a rising `wr_clk` edge only when `wr_en_a_n` and `wr_en_b_n` are both 0 and `full` is 0. With either enable at 1, nothing is stored.
- R2: A read is accepted at a rising `rd_clk` edge only when `rd_en_a_n` and `rd_en_b_n` are both 0 and `empty` is 0. The accepted word appears on `rd_data` after that edge, and words come out in write order. With either enable at 1, the read pointer does not move.
- R3: `full` is 1 while the stored count equals DEPTH. Writes offered while full are dropped and never appear at the output.
- R4: `empty` is 1 while no word is stored. Reads requested while empty leave the read position unchanged.
- R5: `almost_full_n` is 0 when the count is DEPTH minus m or more, and 1 when the count is DEPTH minus (m+1) or less. It changes only at `wr_clk` edges.
- R6: `almost_empty_n` is 0 when the count is n or less, and 1 when the count is n+1 or more. It changes only at `rd_clk` edges.
- R7: A transfer on a flag's own side updates that flag at the same edge. A transfer on the other side reaches the flag within four edges of the flag's own clock. The Gray pointers change at most one bit per edge.
- R8: The almost-full offset m loads from `af_ofs` when `af_ofs_ld` is 1 at a `wr_clk` edge. The almost-empty offset n loads from `ae_ofs` when `ae_ofs_ld` is 1 at a `rd_clk` edge. A new offset governs the flag from that same edge.
- R9: While `rst_n` is 0, the FIFO is empty and m = n = 7. The outputs are then `full`=0, `empty`=1, `almost_full_n`=1, `almost_empty_n`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en_a_n | input | 1 | First write enable, active low |
| wr_en_b_n | input | 1 | Second write enable, active low |
| wr_data | input | 9 | Word to store |
| af_ofs | input | log2(DEPTH) | Almost-full offset m |
| af_ofs_ld | input | 1 | Load strobe for m, write clock |
| rd_clk | input | 1 | Read-side clock |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| ae_ofs | input | log2(DEPTH) | Almost-empty offset n |
| ae_ofs_ld | input | 1 | Load strobe for n, read clock |
| rd_data | output | 9 | Registered read word |
| full | output | 1 | No room; write side |
| empty | output | 1 | No data; read side |
| almost_full_n | output | 1 | Active-low almost-full flag |
| almost_empty_n | output | 1 | Active-low almost-empty flag |

## Verification
Several results are due at the very edge that caused them, and the bench samples these at the following falling edge:
- `rd_data` after an accepted read.
- Each side's own flags after that side's transfer.
- A flag after its offset is loaded.

A result caused by the opposite domain needs two synchronizer stages plus the flag register. Before the bench compares any flag after a burst, it waits eight edges of each clock. That wait is beyond the four-edge bound, so no check depends on the phase between the clocks. The vector table holds flag values worked out by hand from the stored count and the offsets.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int WORD_W    = 9;
  localparam int PTR_MAX_W = 14;
  localparam int RST_OFS   = 7;

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [PTR_MAX_W-1:0] wide_ptr_t;

  function automatic wide_ptr_t to_gray(wide_ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic wide_ptr_t from_gray(wide_ptr_t g);
    wide_ptr_t b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_a_n,
  input  logic          en_b_n,
  input  logic [AW-1:0] ofs_in,
  input  logic          ofs_ld,
  input  logic [PW-1:0] rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] ptr_bin,
  output logic [PW-1:0] ptr_gray,
  output logic          full,
  output logic          af_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] rbin_s, ptr_d, cnt_d, thr_d;
  logic [AW-1:0] ofs_q, ofs_d;
  logic          full_d, af_n_d;

  always_comb begin
    rbin_s = PW'(from_gray(PTR_MAX_W'(rgray_s)));
    we     = !en_a_n && !en_b_n && !full;
    ptr_d  = ptr_bin + PW'(we);
    cnt_d  = ptr_d - rbin_s;
    ofs_d  = ofs_ld ? ofs_in : ofs_q;
    thr_d  = DEPTH_P - PW'(ofs_d);
    full_d = (cnt_d == DEPTH_P);
    af_n_d = !(cnt_d >= thr_d);
  end

  assign waddr = ptr_bin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_bin  <= '0;
      ptr_gray <= '0;
      ofs_q    <= AW'(RST_OFS);
      full     <= 1'b0;
      af_n     <= 1'b1;
    end else begin
      ptr_bin  <= ptr_d;
      ptr_gray <= PW'(to_gray(PTR_MAX_W'(ptr_d)));
      ofs_q    <= ofs_d;
      full     <= full_d;
      af_n     <= af_n_d;
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_a_n,
  input  logic          en_b_n,
  input  logic [AW-1:0] ofs_in,
  input  logic          ofs_ld,
  input  logic [PW-1:0] wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] ptr_bin,
  output logic [PW-1:0] ptr_gray,
  output logic          empty,
  output logic          ae_n
);
  logic [PW-1:0] wbin_s, ptr_d, cnt_d;
  logic [AW-1:0] ofs_q, ofs_d;
  logic          empty_d, ae_n_d;

  always_comb begin
    wbin_s  = PW'(from_gray(PTR_MAX_W'(wgray_s)));
    re      = !en_a_n && !en_b_n && !empty;
    ptr_d   = ptr_bin + PW'(re);
    cnt_d   = wbin_s - ptr_d;
    ofs_d   = ofs_ld ? ofs_in : ofs_q;
    empty_d = (cnt_d == '0);
    ae_n_d  = !(cnt_d <= PW'(ofs_d));
  end

  assign raddr = ptr_bin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_bin  <= '0;
      ptr_gray <= '0;
      ofs_q    <= AW'(RST_OFS);
      empty    <= 1'b1;
      ae_n     <= 1'b0;
    end else begin
      ptr_bin  <= ptr_d;
      ptr_gray <= PW'(to_gray(PTR_MAX_W'(ptr_d)));
      ofs_q    <= ofs_d;
      empty    <= empty_d;
      ae_n     <= ae_n_d;
    end
  end
endmodule

// File: rtl/dcfifo_thresh.sv
module dcfifo_thresh
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en_a_n,
  input  logic          wr_en_b_n,
  input  logic [8:0]    wr_data,
  input  logic [AW-1:0] af_ofs,
  input  logic          af_ofs_ld,
  input  logic          rd_clk,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic [AW-1:0] ae_ofs,
  input  logic          ae_ofs_ld,
  output logic [8:0]    rd_data,
  output logic          full,
  output logic          empty,
  output logic          almost_full_n,
  output logic          almost_empty_n
);
  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wr_ptr_bin, rd_ptr_bin;
  logic [PW-1:0] wr_ptr_gray, rd_ptr_gray;
  logic [PW-1:0] wgray_in_rd, rgray_in_wr;

  dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .en_a_n(wr_en_a_n), .en_b_n(wr_en_b_n),
    .ofs_in(af_ofs), .ofs_ld(af_ofs_ld), .rgray_s(rgray_in_wr),
    .we(we), .waddr(waddr), .ptr_bin(wr_ptr_bin), .ptr_gray(wr_ptr_gray),
    .full(full), .af_n(almost_full_n)
  );

  dcf_rd_ctl #(.AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .en_a_n(rd_en_a_n), .en_b_n(rd_en_b_n),
    .ofs_in(ae_ofs), .ofs_ld(ae_ofs_ld), .wgray_s(wgray_in_rd),
    .re(re), .raddr(raddr), .ptr_bin(rd_ptr_bin), .ptr_gray(rd_ptr_gray),
    .empty(empty), .ae_n(almost_empty_n)
  );

  dcf_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_ptr_gray), .q(wgray_in_rd)
  );

  dcf_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rd_ptr_gray), .q(rgray_in_wr)
  );

  dcf_ram #(.AW(AW), .DW(WORD_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rst_n(rst_n), .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int PW = 9
) (
  input logic          rst_n,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_en_a_n,
  input logic          wr_en_b_n,
  input logic          rd_en_a_n,
  input logic          rd_en_b_n,
  input logic          full,
  input logic          empty,
  input logic          almost_full_n,
  input logic          almost_empty_n,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray
);
  // R1
  wr_gate_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en_a_n || wr_en_b_n) |=> $stable(wr_ptr));

  // R2
  rd_gate_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en_a_n || rd_en_b_n) |=> $stable(rd_ptr));

  // R3
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |=> $stable(wr_ptr));

  // R4
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |=> $stable(rd_ptr));

  // R5
  full_implies_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> !almost_full_n);

  // R6
  empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> !almost_empty_n);

  // R7
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wr_gray ^ $past(wr_gray)));

  // R7
  rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $onehot0(rd_gray ^ $past(rd_gray)));
endmodule

bind dcfifo_thresh dcf_chk #(.PW(PW)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk),
  .wr_en_a_n(wr_en_a_n), .wr_en_b_n(wr_en_b_n),
  .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
  .full(full), .empty(empty),
  .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
  .wr_ptr(wr_ptr_bin), .rd_ptr(rd_ptr_bin),
  .wr_gray(wr_ptr_gray), .rd_gray(rd_ptr_gray)
);

// File: tb/dcfifo_thresh_tb.sv
`timescale 1ns/1ps
module dcfifo_thresh_tb;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  typedef struct packed {
    logic [1:0] op;     // 0 write, 1 read, 2 load m, 3 load n
    logic [9:0] arg;
    logic [3:0] flags;  // {almost_full_n, almost_empty_n, full, empty}
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{2'd0, 10'd7,   4'b1000},
    '{2'd0, 10'd1,   4'b1100},
    '{2'd2, 10'd20,  4'b1100},
    '{2'd0, 10'd227, 4'b1100},
    '{2'd0, 10'd1,   4'b0100},
    '{2'd1, 10'd1,   4'b1100},
    '{2'd3, 10'd100, 4'b1100},
    '{2'd1, 10'd134, 4'b1100},
    '{2'd1, 10'd1,   4'b1000},
    '{2'd1, 10'd100, 4'b1001},
    '{2'd0, 10'd256, 4'b0110},
    '{2'd0, 10'd5,   4'b0110},
    '{2'd1, 10'd256, 4'b1001},
    '{2'd1, 10'd3,   4'b1001},
    '{2'd2, 10'd0,   4'b1001},
    '{2'd0, 10'd255, 4'b1100},
    '{2'd0, 10'd1,   4'b0110},
    '{2'd1, 10'd256, 4'b1001}
  };

  logic          rst_n = 1'b0;
  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_en_a_n = 1'b1, wr_en_b_n = 1'b1;
  logic          rd_en_a_n = 1'b1, rd_en_b_n = 1'b1;
  logic [8:0]    wr_data = '0;
  logic [AW-1:0] af_ofs = '0, ae_ofs = '0;
  logic          af_ofs_ld = 1'b0, ae_ofs_ld = 1'b0;
  logic [8:0]    rd_data;
  logic          full, empty, almost_full_n, almost_empty_n;

  int checks = 0, errors = 0;
  int mcount = 0;
  logic [8:0] wpat = 9'd1;
  logic [8:0] model_q [$];

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dcfifo_thresh #(.DEPTH(DEPTH)) u_dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en_a_n(wr_en_a_n), .wr_en_b_n(wr_en_b_n),
    .wr_data(wr_data), .af_ofs(af_ofs), .af_ofs_ld(af_ofs_ld),
    .rd_clk(rd_clk), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
    .ae_ofs(ae_ofs), .ae_ofs_ld(ae_ofs_ld), .rd_data(rd_data),
    .full(full), .empty(empty), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_write(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en_a_n = 1'b0; wr_en_b_n = 1'b0; wr_data = wpat;
      @(posedge wr_clk);
      if (mcount < DEPTH) begin
        model_q.push_back(wpat);
        mcount++;
      end
      wpat = wpat + 9'd1;
    end
    @(negedge wr_clk);
    wr_en_a_n = 1'b1; wr_en_b_n = 1'b1;
  endtask

  task automatic do_read(input int n);
    for (int i = 0; i < n; i++) begin
      logic [8:0] exp;
      logic       got;
      @(negedge rd_clk);
      rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
      @(posedge rd_clk);
      got = 1'b0; exp = '0;
      if (mcount > 0) begin
        exp = model_q.pop_front();
        mcount--;
        got = 1'b1;
      end
      @(negedge rd_clk);
      rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
      if (got) chk(rd_data == exp, "R2 read order", int'(rd_data), int'(exp));
    end
  endtask

  task automatic load_m(input int v);
    @(negedge wr_clk);
    af_ofs = AW'(v); af_ofs_ld = 1'b1;
    @(negedge wr_clk);
    af_ofs_ld = 1'b0;
  endtask

  task automatic load_n(input int v);
    @(negedge rd_clk);
    ae_ofs = AW'(v); ae_ofs_ld = 1'b1;
    @(negedge rd_clk);
    ae_ofs_ld = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(posedge wr_clk);
    repeat (8) @(posedge rd_clk);
    @(negedge rd_clk);
  endtask

  function automatic int flags4();
    return int'({almost_full_n, almost_empty_n, full, empty});
  endfunction

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wr_clk);
    // R9 reset state
    chk(flags4() == 4'b1001, "R9 reset flags", flags4(), 4'b1001);
    chk(rd_data == 9'd0, "R9 reset data", int'(rd_data), 0);
    rst_n = 1'b1;
    settle();

    // Vector table: R3 R4 R5 R6 R8 flag values after each settled step
    for (int v = 0; v < 18; v++) begin
      case (VECS[v].op)
        2'd0: do_write(int'(VECS[v].arg));
        2'd1: do_read(int'(VECS[v].arg));
        2'd2: load_m(int'(VECS[v].arg));
        default: load_n(int'(VECS[v].arg));
      endcase
      settle();
      chk(flags4() == int'(VECS[v].flags), "R3 R4 R5 R6 flags", flags4(), int'(VECS[v].flags));
    end

    // R1: a single write enable stores nothing
    @(negedge wr_clk); wr_en_a_n = 1'b0; wr_en_b_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    wr_en_a_n = 1'b1; wr_en_b_n = 1'b0;
    repeat (4) @(negedge wr_clk);
    wr_en_b_n = 1'b1;
    settle();
    chk(empty == 1'b1, "R1 single enable write", int'(empty), 1);

    // R2: a single read enable does not consume
    do_write(1);
    settle();
    @(negedge rd_clk); rd_en_a_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    rd_en_b_n = 1'b1;
    settle();
    chk(empty == 1'b0, "R2 single enable read", int'(empty), 0);
    do_read(1);
    settle();
    chk(empty == 1'b1, "R4 drained", int'(empty), 1);

    // R5 R7: own-side write moves almost-full at that same edge
    load_m(7);
    do_write(DEPTH - 8);
    chk(almost_full_n == 1'b1, "R5 below threshold", int'(almost_full_n), 1);
    do_write(1);
    chk(almost_full_n == 1'b0, "R7 same-edge assert", int'(almost_full_n), 0);

    // R8: a new offset applies at its load edge
    load_m(5);
    chk(almost_full_n == 1'b1, "R8 load m raises", int'(almost_full_n), 1);
    load_m(7);
    chk(almost_full_n == 1'b0, "R8 load m lowers", int'(almost_full_n), 0);

    // R7: a read is seen by almost-full after synchronization
    do_read(1);
    settle();
    chk(almost_full_n == 1'b1, "R7 cross-domain release", int'(almost_full_n), 1);

    // R6 R8: almost-empty follows n loaded on the read clock
    load_n(248);
    chk(almost_empty_n == 1'b0, "R6 count at n", int'(almost_empty_n), 0);
    load_n(247);
    chk(almost_empty_n == 1'b1, "R6 count at n+1", int'(almost_empty_n), 1);
    do_read(1);
    chk(almost_empty_n == 1'b0, "R7 read-side same edge", int'(almost_empty_n), 0);
    do_read(DEPTH - 9);
    settle();
    chk(flags4() == 4'b1001, "R4 final drain", flags4(), 4'b1001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule